// File: doc/BRIEF.md
# Programmable Wait-State Bus Interface

This block sits between a synchronous system bus and a memory array and decides how long each access takes. When the bus raises its data strobe, the block holds off the transfer for a number of wait states chosen by a 2-bit field in a small control register. It then raises a one-cycle acknowledge, which is also the cycle in which the array transfers the data. The field's encoding is not monotonic: one of the four codes gives the shortest cycle, with no wait states.

Two kinds of access ignore the programmed count. The later beats of a burst always run at the shortest timing. Program-margin and erase-margin reads run at fixed cycle lengths set by parameters. The control register can always be read. A write changes it only when the writer is in supervisor mode and the unlock input is high.

Top module: `waitstate_bif`

## Requirements
- R1: After a synchronous reset the wait field holds 00, `reg_rdata` is 0, and `bus_ack` and `mem_we` are low.
- R2: With wait field 11, a normal non-burst access acknowledges one clock after the strobe cycle, giving a 2-clock bus cycle.
- R3: Wait codes 00, 01 and 10 insert 1, 2 and 3 wait states. The acknowledge then comes 2, 3 or 4 clocks after the strobe cycle (3-, 4- and 5-clock bus cycles).
- R4: A burst continuation beat (`bus_burst_cont`=1) acknowledges one clock after its strobe for any wait code. A first beat (`bus_burst_cont`=0) uses the programmed count.
- R5: `bus_kind` 01 (program-margin read) gives a bus cycle of `PGM_MARGIN_CLKS` clocks (default 8) and 10 (erase-margin read) gives `ERS_MARGIN_CLKS` clocks (default 10), whatever the wait field and the burst flag hold. `bus_kind` 00 and 11 are normal accesses.
- R6: `bus_ack` is high for exactly one clock per access. `mem_we` is high in that same clock only if `bus_write` was high with the strobe.
- R7: A strobe that arrives while an access is in progress, including its acknowledge cycle, is ignored. A strobe in the clock after the acknowledge starts a new access.
- R8: A register write loads `reg_wdata[7:6]` into the wait field only when `reg_supv` and `reg_unlock` are both 1. Otherwise the field keeps its value.
- R9: `reg_rdata[7:6]` always shows the wait field and `reg_rdata[5:0]` always reads 0.
- R10: A change of the wait field during an access does not change the length of that access. It takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_strobe | input | 1 | Data strobe; starts an access when the block is idle |
| bus_write | input | 1 | Access is a write (sampled with the strobe) |
| bus_burst_cont | input | 1 | Access is a later beat of a burst |
| bus_kind | input | 2 | 00/11 normal, 01 program-margin read, 10 erase-margin read |
| bus_ack | output | 1 | One-cycle acknowledge / data-transfer cycle |
| mem_we | output | 1 | Array write enable, high in the acknowledge cycle of writes |
| reg_wr | input | 1 | Control register write request |
| reg_supv | input | 1 | Writer is in supervisor mode |
| reg_unlock | input | 1 | Unlock input; writes are refused while low |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |

## Verification
The assertions assume that `bus_kind`, `bus_burst_cont` and `bus_write` are meaningful only in a cycle where the strobe is sampled, and that they are never unknown at that edge. They also assume register writes can arrive in any cycle, including during an access. The stimulus changes every input on the falling clock edge, so each value is stable across the rising edge that samples it. Strobes are single-cycle pulses, except in the scenarios that deliberately hold or repeat the strobe to check that it is ignored while the block is busy.

// File: rtl/waitstate_bif_pkg.sv
package waitstate_bif_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL  = 2'b00,
    KIND_PGM_MRG = 2'b01,
    KIND_ERS_MRG = 2'b10,
    KIND_NORMAL2 = 2'b11
  } acc_kind_e;

  // Non-monotonic field decode: code 11 is the fastest setting.
  function automatic logic [1:0] code_to_waits(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/waitstate_bif_reg.sv
module waitstate_bif_reg #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             supv,
  input  logic             unlock,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [1:0]       wait_code
);
  localparam int FLD_MSB = REG_W - 1;

  logic [1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= 2'b00;
    end else if (wr && supv && unlock) begin
      code_q <= wdata[FLD_MSB -: 2];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[FLD_MSB -: 2] = code_q;
  end

  assign wait_code = code_q;
endmodule

// File: rtl/waitstate_bif_len.sv
module waitstate_bif_len
  import waitstate_bif_pkg::*;
#(
  parameter int PGM_MARGIN_CLKS = 8,
  parameter int ERS_MARGIN_CLKS = 10,
  parameter int CW = 5
) (
  input  logic [1:0]    wait_code,
  input  logic [1:0]    kind,
  input  logic          burst_cont,
  output logic [CW-1:0] waits
);
  // A bus cycle of N clocks carries N-2 wait states.
  localparam int PGM_WAITS = PGM_MARGIN_CLKS - 2;
  localparam int ERS_WAITS = ERS_MARGIN_CLKS - 2;

  always_comb begin
    case (acc_kind_e'(kind))
      KIND_PGM_MRG: waits = CW'(PGM_WAITS);
      KIND_ERS_MRG: waits = CW'(ERS_WAITS);
      default: begin
        if (burst_cont) waits = '0;
        else            waits = CW'(code_to_waits(wait_code));
      end
    endcase
  end
endmodule

// File: rtl/waitstate_bif_seq.sv
module waitstate_bif_seq #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          write,
  input  logic [CW-1:0] waits,
  output logic          ack,
  output logic          we,
  output logic          busy
);
  logic          wait_q;
  logic          ack_q;
  logic          we_q;
  logic          wr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= 1'b0;
      ack_q  <= 1'b0;
      we_q   <= 1'b0;
      wr_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      we_q  <= 1'b0;
      if (!wait_q && !ack_q) begin
        if (strobe) begin
          wr_q <= write;
          if (waits == '0) begin
            ack_q <= 1'b1;
            we_q  <= write;
          end else begin
            wait_q <= 1'b1;
            cnt_q  <= waits;
          end
        end
      end else if (wait_q) begin
        if (cnt_q == CW'(1)) begin
          wait_q <= 1'b0;
          ack_q  <= 1'b1;
          we_q   <= wr_q;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

  assign ack  = ack_q;
  assign we   = we_q;
  assign busy = wait_q | ack_q;
endmodule

// File: rtl/waitstate_bif.sv
module waitstate_bif #(
  parameter int PGM_MARGIN_CLKS = 8,
  parameter int ERS_MARGIN_CLKS = 10,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_strobe,
  input  logic             bus_write,
  input  logic             bus_burst_cont,
  input  logic [1:0]       bus_kind,
  output logic             bus_ack,
  output logic             mem_we,
  input  logic             reg_wr,
  input  logic             reg_supv,
  input  logic             reg_unlock,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);
  localparam int MAX_CLKS = (PGM_MARGIN_CLKS > ERS_MARGIN_CLKS) ? PGM_MARGIN_CLKS : ERS_MARGIN_CLKS;
  localparam int CW = $clog2(MAX_CLKS) + 1;

  logic [1:0]    wait_code;
  logic [CW-1:0] waits;
  logic          seq_busy;

  waitstate_bif_reg #(.REG_W(REG_W)) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .supv(reg_supv), .unlock(reg_unlock),
    .wdata(reg_wdata), .rdata(reg_rdata), .wait_code(wait_code)
  );

  waitstate_bif_len #(
    .PGM_MARGIN_CLKS(PGM_MARGIN_CLKS), .ERS_MARGIN_CLKS(ERS_MARGIN_CLKS), .CW(CW)
  ) u_len (
    .wait_code(wait_code), .kind(bus_kind), .burst_cont(bus_burst_cont), .waits(waits)
  );

  waitstate_bif_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .strobe(bus_strobe), .write(bus_write), .waits(waits),
    .ack(bus_ack), .we(mem_we), .busy(seq_busy)
  );
endmodule

// File: rtl/waitstate_bif_chk.sv
module waitstate_bif_chk #(
  parameter int PGM_MARGIN_CLKS = 8,
  parameter int ERS_MARGIN_CLKS = 10
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_strobe,
  input logic       bus_burst_cont,
  input logic [1:0] bus_kind,
  input logic       bus_ack,
  input logic       mem_we,
  input logic       reg_wr,
  input logic       reg_supv,
  input logic       reg_unlock,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       seq_busy
);
  logic        accept, normal, mon_q;
  logic [15:0] mcnt_q, mexp_q;

  assign accept = bus_strobe && !seq_busy;
  assign normal = (bus_kind[1] == bus_kind[0]);

  // Independent window counter for margin reads.
  always_ff @(posedge clk) begin
    if (rst) begin
      mon_q  <= 1'b0;
      mcnt_q <= '0;
      mexp_q <= '0;
    end else if (!mon_q && accept && !normal) begin
      mon_q  <= 1'b1;
      mcnt_q <= 16'd1;
      mexp_q <= (bus_kind == 2'b01) ? 16'(PGM_MARGIN_CLKS - 1) : 16'(ERS_MARGIN_CLKS - 1);
    end else if (mon_q) begin
      if (bus_ack) mon_q <= 1'b0;
      mcnt_q <= mcnt_q + 16'd1;
    end
  end

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (rst) bus_ack |=> !bus_ack);
  assert_we_in_ack_R6: assert property (@(posedge clk) disable iff (rst) mem_we |-> bus_ack);
  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst) reg_rdata[5:0] == 6'd0);
  assert_reg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_supv && reg_unlock) |=> $stable(reg_rdata[7:6]));
  assert_reg_load_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_supv && reg_unlock) |=> reg_rdata[7:6] == $past(reg_wdata[7:6]));
  assert_zero_wait_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && normal && !bus_burst_cont && reg_rdata[7:6] == 2'b11) |=> bus_ack);
  assert_one_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && normal && !bus_burst_cont && reg_rdata[7:6] == 2'b00) |=> !bus_ack ##1 bus_ack);
  assert_burst_beat_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && normal && bus_burst_cont) |=> bus_ack);
  assert_margin_len_R5: assert property (@(posedge clk) disable iff (rst)
    (mon_q && bus_ack) |-> mcnt_q == mexp_q);
  assert_margin_early_R5: assert property (@(posedge clk) disable iff (rst)
    (mon_q && mcnt_q < mexp_q) |-> !bus_ack);
  assert_busy_ack_R7: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> seq_busy);
endmodule

bind waitstate_bif waitstate_bif_chk #(
  .PGM_MARGIN_CLKS(PGM_MARGIN_CLKS), .ERS_MARGIN_CLKS(ERS_MARGIN_CLKS)
) u_chk (
  .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_burst_cont(bus_burst_cont),
  .bus_kind(bus_kind), .bus_ack(bus_ack), .mem_we(mem_we), .reg_wr(reg_wr),
  .reg_supv(reg_supv), .reg_unlock(reg_unlock), .reg_wdata(reg_wdata[7:0]),
  .reg_rdata(reg_rdata[7:0]), .seq_busy(seq_busy)
);

// File: tb/waitstate_bif_tb.sv
module waitstate_bif_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_strobe = 1'b0, bus_write = 1'b0, bus_burst_cont = 1'b0;
  logic [1:0] bus_kind = 2'b00;
  logic       bus_ack, mem_we;
  logic       reg_wr = 1'b0, reg_supv = 1'b0, reg_unlock = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  waitstate_bif u_dut (
    .clk(clk), .rst(rst), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_burst_cont(bus_burst_cont), .bus_kind(bus_kind), .bus_ack(bus_ack),
    .mem_we(mem_we), .reg_wr(reg_wr), .reg_supv(reg_supv), .reg_unlock(reg_unlock),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic supv, input logic unl, input logic [7:0] d);
    reg_wr = 1'b1; reg_supv = supv; reg_unlock = unl; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_supv = 1'b0; reg_unlock = 1'b0; reg_wdata = 8'h00;
  endtask

  // One access; ack expected in the (len-1)th clock after the strobe cycle.
  task automatic access(input logic [1:0] kind, input logic burst, input logic wr,
                        input int len, input string req);
    int bad_at = 0;
    bus_strobe = 1'b1; bus_kind = kind; bus_burst_cont = burst; bus_write = wr;
    for (int i = 1; i <= len + 1; i++) begin
      @(negedge clk);
      if (i == 1) begin bus_strobe = 1'b0; bus_kind = 2'b00; bus_burst_cont = 1'b0; bus_write = 1'b0; end
      if (bad_at == 0 && (bus_ack !== (i == len - 1) || mem_we !== (wr && i == len - 1))) bad_at = i;
    end
    check(bad_at == 0, req, bad_at, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1", int'(reg_rdata), 0);
    check(bus_ack == 1'b0 && mem_we == 1'b0, "R1", int'({bus_ack, mem_we}), 0);
  endtask

  task automatic t_register;
    reg_write(1'b1, 1'b0, 8'hFF);
    check(reg_rdata == 8'h00, "R8 locked", int'(reg_rdata), 0);
    reg_write(1'b0, 1'b1, 8'hFF);
    check(reg_rdata == 8'h00, "R8 user", int'(reg_rdata), 0);
    reg_write(1'b1, 1'b1, 8'hFF);
    check(reg_rdata == 8'hC0, "R9", int'(reg_rdata), 8'hC0);
    reg_write(1'b1, 1'b1, 8'h40);
    check(reg_rdata == 8'h40, "R8 load", int'(reg_rdata), 8'h40);
    reg_write(1'b1, 1'b0, 8'hBF);
    check(reg_rdata == 8'h40, "R8 hold", int'(reg_rdata), 8'h40);
  endtask

  task automatic t_wait_codes;
    reg_write(1'b1, 1'b1, 8'hC0);
    access(2'b00, 1'b0, 1'b0, 2, "R2 code11 read");
    access(2'b11, 1'b0, 1'b1, 2, "R2 code11 write");
    reg_write(1'b1, 1'b1, 8'h00);
    access(2'b00, 1'b0, 1'b1, 3, "R3 code00");
    reg_write(1'b1, 1'b1, 8'h40);
    access(2'b00, 1'b0, 1'b0, 4, "R3 code01");
    reg_write(1'b1, 1'b1, 8'h80);
    access(2'b00, 1'b0, 1'b1, 5, "R3 code10 R6");
  endtask

  task automatic t_burst;
    reg_write(1'b1, 1'b1, 8'h80);
    access(2'b00, 1'b0, 1'b0, 5, "R4 first beat");
    access(2'b00, 1'b1, 1'b0, 2, "R4 later beat");
    access(2'b00, 1'b1, 1'b1, 2, "R4 later beat write");
  endtask

  task automatic t_margin;
    reg_write(1'b1, 1'b1, 8'hC0);
    access(2'b01, 1'b0, 1'b0, 8, "R5 pgm margin");
    access(2'b10, 1'b0, 1'b0, 10, "R5 ers margin");
    reg_write(1'b1, 1'b1, 8'h80);
    access(2'b01, 1'b1, 1'b0, 8, "R5 pgm over burst");
  endtask

  task automatic t_busy;
    int bad_at = 0;
    reg_write(1'b1, 1'b1, 8'h80);
    // Strobe held high through the whole access, including its ack cycle.
    bus_strobe = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (bad_at == 0 && bus_ack !== (i == 4)) bad_at = i;
    end
    @(negedge clk);
    bus_strobe = 1'b0;
    // The strobe sampled at the end of the ack cycle is ignored: no second ack.
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (bad_at == 0 && bus_ack !== 1'b0) bad_at = 10 + i;
    end
    check(bad_at == 0, "R7 held strobe", bad_at, 0);
    // Back to back: strobe in the clock after the ack starts a new access.
    reg_write(1'b1, 1'b1, 8'h00);
    access(2'b00, 1'b0, 1'b0, 3, "R7 first");
    bus_strobe = 1'b1;
    @(negedge clk);
    check(bus_ack == 1'b0, "R7 b2b early", int'(bus_ack), 0);
    bus_strobe = 1'b0;
    @(negedge clk);
    check(bus_ack == 1'b1, "R7 b2b ack", int'(bus_ack), 1);
  endtask

  task automatic t_midchange;
    int bad_at = 0;
    reg_write(1'b1, 1'b1, 8'h80);
    bus_strobe = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 1) begin bus_strobe = 1'b0; reg_wr = 1'b1; reg_supv = 1'b1; reg_unlock = 1'b1; reg_wdata = 8'hC0; end
      if (i == 2) begin reg_wr = 1'b0; reg_supv = 1'b0; reg_unlock = 1'b0; end
      if (bad_at == 0 && bus_ack !== (i == 4)) bad_at = i;
    end
    check(bad_at == 0, "R10 in flight", bad_at, 0);
    access(2'b00, 1'b0, 1'b0, 2, "R10 next access");
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_register();
    t_wait_codes();
    t_burst();
    t_margin();
    t_busy();
    t_midchange();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule